// File: doc/BRIEF.md
# Byte-Wide Serial Shift Data Path

This block moves one byte at a time over a four-wire synchronous serial link and can act as either end of the link. On the bus side there is one data location. A write puts the outgoing byte straight into the shift register. A read returns a separate receive buffer, which is refreshed only when a byte has been fully exchanged. A completion flag tells software when a new byte is waiting. If software writes while a byte is still moving, the write is dropped and a collision pulse is raised.

As link master, the block makes the serial clock from the system clock with a fixed divider, sends on its data-out line and receives on its data-in line. As link slave, it resynchronises the incoming clock and select, receives on the master-out line and drives the master-in line only while it is selected. A configuration input makes the master data output open-drain, so it only ever pulls low. The serial clock idles low. Each bit is launched on the rising edge and captured on the falling edge, most significant bit first.

Top module: `spi_xfer_engine`

## Requirements
- R1: A write (`wr_en` high while idle) loads `wr_data` directly into the shift register. In master mode the transfer starts on the following cycle, and that byte appears on the data-out line, bit 7 first.
- R2: A write made while a transfer is in progress is ignored: the byte sent is unchanged. `wr_collide` is high for exactly the one cycle after such a write.
- R3: Each transfer moves exactly eight bits and exchanges the two bytes. Afterwards `rd_data` holds the byte shifted in from the partner.
- R4: `rd_data` keeps the previously received byte while a transfer runs and changes only when a transfer completes.
- R5: `done_flag` is set when a transfer completes. A cycle with `rd_en` high while the flag is already set clears it on the next cycle, unless a new transfer completes in that same cycle, in which case setting wins.
- R6: In slave mode, `miso_oe` is high only while `ss_n_in` is low.
- R7: In master mode, `sck_oe` = 1 and `miso_oe` = 0. In slave mode, `sck_oe` = 0 and `mosi_oe` = 0.
- R8: With `cfg_odrain` = 1 in master mode, the master data output is never driven high (never `mosi_oe` = 1 with `mosi_out` = 1). The line seen through a pull-up still carries the correct bits.
- R9: SCK idles low. Bits change on the rising SCK edge and are sampled on the falling edge. In master mode each SCK half period lasts CLK_DIV/2 system cycles, giving 8*CLK_DIV/2 high cycles per byte.
- R10: Reset clears `done_flag`, `wr_collide` and `sck_out`. The shift register and the receive buffer are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master | input | 1 | 1 = link master, 0 = link slave |
| cfg_odrain | input | 1 | 1 = master data output is open-drain |
| wr_en | input | 1 | Bus write strobe to the data location |
| wr_data | input | DATA_W | Byte to send |
| rd_en | input | 1 | Bus read strobe, clears a set flag |
| rd_data | output | DATA_W | Receive buffer |
| done_flag | output | 1 | Transfer-complete flag |
| wr_collide | output | 1 | One-cycle pulse after a refused write |
| sck_in | input | 1 | Serial clock pin input (slave) |
| sck_out | output | 1 | Serial clock pin output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| ss_n_in | input | 1 | Active-low slave select input |
| mosi_in | input | 1 | Master-out line input (slave) |
| mosi_out | output | 1 | Master-out line output value |
| mosi_oe | output | 1 | Master-out line output enable |
| miso_in | input | 1 | Master-in line input (master) |
| miso_out | output | 1 | Master-in line output value |
| miso_oe | output | 1 | Master-in line output enable |

## Verification
The assertions assume the mode inputs stay constant for the whole of a transfer. In slave mode they also assume the external clock phases last longer than the synchroniser delay, so every edge is seen once and the data-in line is stable when its falling edge is detected. The stimulus changes `cfg_master` and `cfg_odrain` only between transfers, when the block is idle. As slave, it holds each SCK level for six system cycles and changes the data-in line only together with a rising SCK. Random bytes and random open-drain settings are mixed with directed collisions, mid-transfer reads and select toggling.

// File: rtl/spi_dp_pkg.sv
package spi_dp_pkg;

   // one-cycle SCK event strobes seen by the shift core
   typedef struct packed {
      logic lead;    // rising SCK: launch next bit
      logic trail;   // falling SCK: capture incoming bit
   } sck_evt_t;

   // output enable for the master data pin; open-drain only sinks a zero
   function automatic logic mosi_drive_en(input logic odrain, input logic bit_v);
      return odrain ? ~bit_v : 1'b1;
   endfunction

endpackage

// File: rtl/spi_sck_master.sv
module spi_sck_master
   import spi_dp_pkg::*;
#(
   parameter int HALF_CYC = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   output logic     sck,
   output sck_evt_t evt
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == CW'(HALF_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         sck <= ~sck;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign evt.lead  = run & wrap & ~sck;
   assign evt.trail = run & wrap & sck;

endmodule

// File: rtl/spi_sck_slave.sv
module spi_sck_slave
   import spi_dp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sck_pin,
   input  logic     ssn_pin,
   output logic     sel,
   output sck_evt_t evt
);
   logic sck_s, ssn_s, sck_d;

   generate
      if (SYNC_STAGES > 0) begin : g_sync
         logic [SYNC_STAGES-1:0] sck_ff, ssn_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_ff <= '0;
               ssn_ff <= '1;
            end else begin
               sck_ff[0] <= sck_pin;
               ssn_ff[0] <= ssn_pin;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sck_ff[i] <= sck_ff[i-1];
                  ssn_ff[i] <= ssn_ff[i-1];
               end
            end
         end
         assign sck_s = sck_ff[SYNC_STAGES-1];
         assign ssn_s = ssn_ff[SYNC_STAGES-1];
      end else begin : g_direct
         assign sck_s = sck_pin;
         assign ssn_s = ssn_pin;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign sel       = ~ssn_s;
   assign evt.lead  = sel & sck_s & ~sck_d;
   assign evt.trail = sel & ~sck_s & sck_d;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         lead,
   input  logic         trail,
   input  logic         abort,
   input  logic         rx_bit,
   output logic         tx_bit,
   output logic [W-1:0] shift_next,
   output logic         last
);
   localparam int BCW = $clog2(W);

   logic [W-1:0]   shreg;
   logic [BCW-1:0] bit_cnt;

   assign shift_next = {shreg[W-2:0], rx_bit};
   assign last       = trail & (bit_cnt == BCW'(W - 1));

   // data register: deliberately left out of reset
   always_ff @(posedge clk) begin
      if (load)       shreg <= load_data;
      else if (trail) shreg <= shift_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         tx_bit  <= 1'b0;
      end else begin
         if (load || abort)  bit_cnt <= '0;
         else if (trail)     bit_cnt <= last ? '0 : bit_cnt + 1'b1;
         if (lead)           tx_bit  <= shreg[W-1];
      end
   end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
   import spi_dp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_odrain,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              done_flag,
   output logic              wr_collide,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              ss_n_in,
   input  logic              mosi_in,
   output logic              mosi_out,
   output logic              mosi_oe,
   input  logic              miso_in,
   output logic              miso_out,
   output logic              miso_oe
);
   localparam int HALF = CLK_DIV / 2;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be an even value of 2 or more");
      end
   endgenerate

   logic              busy, load, abort, xfer_last, tx_bit, rx_bit, s_sel, m_sck;
   logic [DATA_W-1:0] shift_next, rx_buf;
   sck_evt_t          m_evt, s_evt, evt;

   assign load   = wr_en & ~busy;
   assign evt    = cfg_master ? m_evt : s_evt;
   assign abort  = ~cfg_master & busy & ~s_sel;
   assign rx_bit = cfg_master ? miso_in : mosi_in;

   spi_sck_master #(.HALF_CYC(HALF)) u_mclk (
      .clk(clk), .rst_n(rst_n), .run(busy & cfg_master), .sck(m_sck), .evt(m_evt)
   );

   spi_sck_slave #(.SYNC_STAGES(SYNC_STAGES)) u_sclk (
      .clk(clk), .rst_n(rst_n), .sck_pin(sck_in), .ssn_pin(ss_n_in),
      .sel(s_sel), .evt(s_evt)
   );

   spi_shift_core #(.W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .load_data(wr_data),
      .lead(evt.lead), .trail(evt.trail), .abort(abort), .rx_bit(rx_bit),
      .tx_bit(tx_bit), .shift_next(shift_next), .last(xfer_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         done_flag  <= 1'b0;
         wr_collide <= 1'b0;
      end else begin
         if (xfer_last || abort)              busy <= 1'b0;
         else if (load && cfg_master)         busy <= 1'b1;
         else if (evt.lead && !cfg_master)    busy <= 1'b1;

         if (xfer_last)                       done_flag <= 1'b1;
         else if (rd_en && done_flag)         done_flag <= 1'b0;

         wr_collide <= wr_en & busy;
      end
   end

   // receive buffer: refreshed only on completion, not reset
   always_ff @(posedge clk) begin
      if (xfer_last) rx_buf <= shift_next;
   end
   assign rd_data = rx_buf;

   assign sck_out  = cfg_master & m_sck;
   assign sck_oe   = cfg_master;
   assign mosi_out = cfg_master & ~cfg_odrain & tx_bit;
   assign mosi_oe  = cfg_master & mosi_drive_en(cfg_odrain, tx_bit);
   assign miso_out = ~cfg_master & tx_bit;
   assign miso_oe  = ~cfg_master & ~ss_n_in;

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_master,
   input logic              cfg_odrain,
   input logic              ss_n_in,
   input logic              wr_en,
   input logic              rd_en,
   input logic              wr_collide,
   input logic              done_flag,
   input logic [DATA_W-1:0] rd_data,
   input logic              miso_oe,
   input logic              mosi_oe,
   input logic              mosi_out,
   input logic              sck_oe,
   input logic              sck_out,
   input logic              busy,
   input logic              xfer_last
);
   // R6
   miso_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_master && ss_n_in) |-> !miso_oe);

   // R8
   odrain_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && cfg_odrain) |-> !(mosi_oe && mosi_out));

   // R7
   master_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_master |-> (sck_oe && !miso_oe));

   // R7
   slave_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master |-> (!sck_oe && !mosi_oe));

   // R2
   collide_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> wr_collide);

   // R2
   collide_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_collide && !$past(wr_en && busy)) |-> 1'b0);

   // R4
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_last |=> $stable(rd_data));

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $past(xfer_last));

   // R5
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && rd_en && !xfer_last) |=> !done_flag);

   // R9
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck_out);

endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_odrain(cfg_odrain),
   .ss_n_in(ss_n_in), .wr_en(wr_en), .rd_en(rd_en), .wr_collide(wr_collide),
   .done_flag(done_flag), .rd_data(rd_data), .miso_oe(miso_oe), .mosi_oe(mosi_oe),
   .mosi_out(mosi_out), .sck_oe(sck_oe), .sck_out(sck_out), .busy(busy),
   .xfer_last(xfer_last)
);

// File: tb/sim_spi_xfer_engine.sv
`timescale 1ns/1ps
module sim_spi_xfer_engine;
   localparam int W    = 8;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_master = 1'b1, cfg_odrain = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic done_flag, wr_collide;
   logic sck_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0, miso_in = 1'b0;
   logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;

   always #10 clk = ~clk;

   spi_xfer_engine #(.DATA_W(W), .CLK_DIV(DIV), .SYNC_STAGES(2)) u0 (.*);

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   // bench-side slave partner for master-mode runs
   logic [W-1:0] part_tx, part_rx;
   int           part_idx;
   logic         mosi_line;
   assign mosi_line = mosi_oe ? mosi_out : 1'b1;   // pull-up

   always @(posedge sck_out) begin
      miso_in <= part_tx[W-1-part_idx];
   end
   always @(negedge sck_out) begin
      part_rx  <= {part_rx[W-2:0], mosi_line};
      part_idx <= part_idx + 1;
   end

   function automatic logic exp_bit(input logic [W-1:0] b, input int i);
      return b[W-1-i];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic read_clear();
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
      chk(done_flag == 1'b0, "R5 flag cleared by read", done_flag, 0);
   endtask

   logic [W-1:0] prev_rx;

   task automatic master_xfer(input logic [W-1:0] tx, input logic [W-1:0] ptx,
                              input logic od, input bit coll);
      int hi = 0, rises = 0, odv = 0;
      logic sck_prev = 1'b0;
      bit got = 1'b0;
      cfg_master = 1'b1;
      cfg_odrain = od;
      part_tx  = ptx;
      part_idx = 0;
      @(negedge clk) begin wr_en = 1'b1; wr_data = tx; end
      @(negedge clk) wr_en = 1'b0;
      for (int c = 0; c < 600; c++) begin
         @(negedge clk);
         if (sck_out) hi++;
         if (sck_out && !sck_prev) rises++;
         sck_prev = sck_out;
         if (od && mosi_oe && mosi_out) odv++;
         if (coll && c == 4) begin wr_en = 1'b1; wr_data = ~tx; end
         if (coll && c == 5) begin
            wr_en = 1'b0;
            chk(wr_collide == 1'b1, "R2 collision pulse", wr_collide, 1);
         end
         if (coll && c == 6) chk(wr_collide == 1'b0, "R2 pulse one cycle", wr_collide, 0);
         if (c == 10) begin
            chk(rd_data == prev_rx, "R4 buffer held mid-transfer", rd_data, prev_rx);
            chk(sck_oe && !miso_oe, "R7 master pin directions", {sck_oe, miso_oe}, 2);
         end
         if (done_flag) begin got = 1'b1; break; end
      end
      chk(got, "R5 flag set at completion", got, 1);
      chk(rd_data == ptx, "R3 received byte", rd_data, ptx);
      chk(part_rx == tx, "R1 R2 byte sent", part_rx, tx);
      chk(rises == W, "R3 eight clock pulses", rises, W);
      chk(hi == W * HALF, "R9 SCK high cycles", hi, W * HALF);
      chk(odv == 0, "R8 open-drain never high", odv, 0);
      chk(sck_out == 1'b0, "R9 SCK idles low", sck_out, 0);
      prev_rx = ptx;
      read_clear();
   endtask

   task automatic slave_xfer(input logic [W-1:0] dut_b, input logic [W-1:0] mb);
      logic [W-1:0] seen = '0;
      cfg_master = 1'b0;
      ss_n_in = 1'b1;
      sck_in = 1'b0;
      @(negedge clk) begin wr_en = 1'b1; wr_data = dut_b; end
      @(negedge clk) wr_en = 1'b0;
      chk(miso_oe == 1'b0, "R6 MISO floats while deselected", miso_oe, 0);
      ss_n_in = 1'b0;
      repeat (4) @(negedge clk);
      chk(miso_oe == 1'b1, "R6 MISO driven while selected", miso_oe, 1);
      chk(!sck_oe && !mosi_oe, "R7 slave pin directions", {sck_oe, mosi_oe}, 0);
      for (int i = 0; i < W; i++) begin
         mosi_in = exp_bit(mb, i);
         sck_in  = 1'b1;
         repeat (6) @(negedge clk);
         seen = {seen[W-2:0], miso_out};
         if (i == 3) chk(rd_data == prev_rx, "R4 buffer held mid-transfer", rd_data, prev_rx);
         sck_in = 1'b0;
         repeat (6) @(negedge clk);
      end
      chk(seen == dut_b, "R9 R1 slave bits MSB first", seen, dut_b);
      chk(done_flag == 1'b1, "R5 slave flag set", done_flag, 1);
      chk(rd_data == mb, "R3 slave received byte", rd_data, mb);
      ss_n_in = 1'b1;
      repeat (4) @(negedge clk);
      chk(miso_oe == 1'b0, "R6 MISO floats after deselect", miso_oe, 0);
      prev_rx = mb;
      read_clear();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(done_flag == 1'b0, "R10 flag after reset", done_flag, 0);
      chk(wr_collide == 1'b0, "R10 collision after reset", wr_collide, 0);
      chk(sck_out == 1'b0, "R10 SCK after reset", sck_out, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(done_flag == 1'b0 && sck_out == 1'b0, "R10 idle after release", done_flag, 0);

      // directed corners
      master_xfer(8'hA5, 8'h3C, 1'b0, 1'b0);
      prev_rx = 8'h3C;
      master_xfer(8'h00, 8'hFF, 1'b1, 1'b1);
      master_xfer(8'hFF, 8'h00, 1'b1, 1'b0);
      master_xfer(8'h81, 8'h7E, 1'b0, 1'b1);
      slave_xfer(8'hC3, 8'h5A);
      slave_xfer(8'h01, 8'h80);

      // constrained random mix, mode changed only while idle
      for (int n = 0; n < 24; n++) begin
         logic [W-1:0] a, b;
         a = W'($urandom);
         b = W'($urandom);
         if ($urandom_range(0, 2) == 0) slave_xfer(a, b);
         else master_xfer(a, b, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
      end

      finish_run();
   end
endmodule